// File: doc/BRIEF.md
# Line Code Zero-Run Detector

This block sits behind an E1/T1 receive line interface and watches the recovered bit stream one bit per receive clock. Each bit arrives as a data bit together with a bipolar-violation marker. The block keeps three sticky status flags. The first flag reports a run of zeros whose length depends on the line mode. The second reports a run of at least sixteen zeros. The third reports a zero-substitution codeword: HDB3 on E1 lines, B8ZS on T1 lines.

Codeword recognition does not depend on whether substitution decoding is switched on elsewhere in the receiver. Software can therefore read the codeword flag to decide which line coding a link is using. Each flag has its own read strobe, which the register interface drives when software reads that flag. A read clears the flag unless a new event arrives in the same cycle.

Top module: `lczd_top`

## Requirements
- R1: Reset clears all three flags and forgets the zero-run length and the recent-symbol history. A codeword is recognised only from symbols that arrive after reset.
- R2: With `t1_mode` = 0 (E1), `run_flag` sets on the fourth consecutive zero of a run. Three zeros do not set it.
- R3: With `t1_mode` = 1 (T1), `run_flag` sets on the eighth consecutive zero of a run. Seven zeros do not set it.
- R4: `run16_flag` sets on the sixteenth consecutive zero in either mode. Fifteen zeros do not set it.
- R5: Any received pulse (`rx_bit` = 1), violation or not, ends the current run. The next zero starts counting from one. `rx_bpv` has no effect while `rx_bit` = 0, so that bit still counts as a zero.
- R6: A run longer than a threshold keeps raising that flag's set condition on every further zero, including runs far past sixteen.
- R7: In E1 mode, `cw_flag` sets on a violation pulse (`rx_bit` = 1, `rx_bpv` = 1) whose two preceding bits were zeros and whose third preceding bit was either a zero or a non-violation pulse.
- R8: In T1 mode, `cw_flag` sets on the last bit of the eight-bit sequence zero, zero, zero, violation, pulse, zero, violation, pulse (oldest first). Here a pulse means `rx_bit` = 1 with `rx_bpv` = 0.
- R9: Only the pattern of the selected mode sets `cw_flag`. No other input gates codeword recognition.
- R10: A set flag stays set until its read strobe is sampled high. It is low from the following clock edge on, unless R11 applies.
- R11: When a flag's set condition and its read strobe occur in the same cycle, the flag is set after that edge.
- R12: Each read strobe affects only its own flag.
- R13: A flag rises at the same clock edge that samples the bit completing its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received bit: 1 = pulse, 0 = zero |
| rx_bpv | input | 1 | Marks the current pulse as a bipolar violation |
| t1_mode | input | 1 | 0 = E1 / HDB3, 1 = T1 / B8ZS |
| rd_run | input | 1 | Read strobe for `run_flag` |
| rd_run16 | input | 1 | Read strobe for `run16_flag` |
| rd_cw | input | 1 | Read strobe for `cw_flag` |
| run_flag | output | 1 | Sticky mode-dependent zero-run flag |
| run16_flag | output | 1 | Sticky sixteen-zero flag |
| cw_flag | output | 1 | Sticky substitution-codeword flag |

## Verification
Every result is due one clock after its stimulus. The bit that completes a run or a codeword, a read strobe, or both together act at the next rising edge and are visible on the flags straight after it. The bench drives each bit and strobe on the falling edge. It then samples all three flags one time unit after the following rising edge and compares them with values it computes for that bit. The run sweeps, the full sweeps of four- and eight-symbol codeword windows in both modes, and the random phase all use this same single-cycle sampling.

// File: rtl/lczd_pkg.sv
package lczd_pkg;

   // Received symbol classes. EMPTY marks history slots not yet filled since reset.
   typedef enum logic [1:0] {
      SYM_ZERO  = 2'b00,
      SYM_PULSE = 2'b01,
      SYM_EMPTY = 2'b10,
      SYM_VIOL  = 2'b11
   } lczd_sym_t;

   localparam int unsigned FLAG_COUNT = 3;
   localparam int unsigned FLG_RUN    = 0;
   localparam int unsigned FLG_RUN16  = 1;
   localparam int unsigned FLG_CW     = 2;

   // Longest codeword window in bit times.
   localparam int unsigned CW_SPAN_T1 = 8;
   localparam int unsigned CW_SPAN_E1 = 4;

   function automatic lczd_sym_t classify(input logic bit_i, input logic bpv_i);
      if (!bit_i)     return SYM_ZERO;
      else if (bpv_i) return SYM_VIOL;
      else            return SYM_PULSE;
   endfunction

endpackage

// File: rtl/lczd_run_counter.sv
module lczd_run_counter #(
   parameter int unsigned RUN_E1   = 4,
   parameter int unsigned RUN_T1   = 8,
   parameter int unsigned RUN_LONG = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_i,
   input  logic t1_mode,
   output logic hit_mode_o,
   output logic hit_long_o
);

   localparam int unsigned CNT_W = $clog2(RUN_LONG + 1);
   localparam logic [CNT_W-1:0] LIM_LONG = CNT_W'(RUN_LONG);
   localparam logic [CNT_W-1:0] LIM_E1   = CNT_W'(RUN_E1);
   localparam logic [CNT_W-1:0] LIM_T1   = CNT_W'(RUN_T1);

   if (RUN_E1 < 1 || RUN_E1 > RUN_LONG) begin : g_bad_e1
      $error("lczd_run_counter: RUN_E1 must lie in 1..RUN_LONG");
   end
   if (RUN_T1 < 1 || RUN_T1 > RUN_LONG) begin : g_bad_t1
      $error("lczd_run_counter: RUN_T1 must lie in 1..RUN_LONG");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d, thr;

   always_comb begin
      if (!zero_i)               cnt_d = '0;
      else if (cnt_q == LIM_LONG) cnt_d = cnt_q;
      else                        cnt_d = cnt_q + 1'b1;
   end

   assign thr        = t1_mode ? LIM_T1 : LIM_E1;
   assign hit_mode_o = zero_i && (cnt_d >= thr);
   assign hit_long_o = zero_i && (cnt_d == LIM_LONG);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_i |=> (cnt_q == '0)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_LONG); // R6
   AST_LONG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_long_o |-> hit_mode_o); // R4
   AST_RUN_HOLDS_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LIM_LONG && zero_i) |=> (cnt_q == LIM_LONG)); // R6

endmodule

// File: rtl/lczd_cw_matcher.sv
module lczd_cw_matcher
   import lczd_pkg::*;
#(
   parameter int unsigned HIST_DEPTH = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  lczd_sym_t sym_i,
   input  logic      t1_mode,
   output logic      hit_o
);

   if (HIST_DEPTH < CW_SPAN_T1) begin : g_bad_depth
      $error("lczd_cw_matcher: HIST_DEPTH too small for the T1 codeword");
   end

   localparam int unsigned OLD = HIST_DEPTH - 1;

   lczd_sym_t hist_q [OLD];
   lczd_sym_t win    [HIST_DEPTH];

   // win[0] is the current symbol, win[k] the symbol k bit times earlier.
   assign win[0] = sym_i;
   for (genvar k = 1; k < HIST_DEPTH; k++) begin : g_win
      assign win[k] = hist_q[k-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < OLD; k++) hist_q[k] <= SYM_EMPTY;
      end else begin
         hist_q[0] <= sym_i;
         for (int k = 1; k < OLD; k++) hist_q[k] <= hist_q[k-1];
      end
   end

   logic e1_hit, t1_hit;

   assign e1_hit = (win[0] == SYM_VIOL) && (win[1] == SYM_ZERO) && (win[2] == SYM_ZERO)
                && ((win[3] == SYM_ZERO) || (win[3] == SYM_PULSE));

   assign t1_hit = (win[0] == SYM_PULSE) && (win[1] == SYM_VIOL) && (win[2] == SYM_ZERO)
                && (win[3] == SYM_PULSE) && (win[4] == SYM_VIOL) && (win[5] == SYM_ZERO)
                && (win[6] == SYM_ZERO)  && (win[7] == SYM_ZERO);

   assign hit_o = t1_mode ? t1_hit : e1_hit;

   AST_E1_ENDS_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && !t1_mode) |-> (sym_i == SYM_VIOL)); // R7
   AST_T1_ENDS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && t1_mode) |-> (sym_i == SYM_PULSE)); // R8
   AST_NO_HIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit_o); // R1

endmodule

// File: rtl/lczd_sticky_flag.sv
module lczd_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R11
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R10
   AST_HOLDS_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(flag_o)); // R10

endmodule

// File: rtl/lczd_top.sv
module lczd_top
   import lczd_pkg::*;
#(
   parameter int unsigned RUN_E1     = 4,
   parameter int unsigned RUN_T1     = 8,
   parameter int unsigned RUN_LONG   = 16,
   parameter int unsigned HIST_DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic rx_bpv,
   input  logic t1_mode,
   input  logic rd_run,
   input  logic rd_run16,
   input  logic rd_cw,
   output logic run_flag,
   output logic run16_flag,
   output logic cw_flag
);

   lczd_sym_t sym;
   logic      hit_mode, hit_long, hit_cw;
   logic [FLAG_COUNT-1:0] set_v, clr_v, flag_v;

   assign sym = classify(rx_bit, rx_bpv);

   lczd_run_counter #(
      .RUN_E1   (RUN_E1),
      .RUN_T1   (RUN_T1),
      .RUN_LONG (RUN_LONG)
   ) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .zero_i     (sym == SYM_ZERO),
      .t1_mode    (t1_mode),
      .hit_mode_o (hit_mode),
      .hit_long_o (hit_long)
   );

   lczd_cw_matcher #(
      .HIST_DEPTH (HIST_DEPTH)
   ) u_cw (
      .clk     (clk),
      .rst_n   (rst_n),
      .sym_i   (sym),
      .t1_mode (t1_mode),
      .hit_o   (hit_cw)
   );

   always_comb begin
      set_v            = '0;
      clr_v            = '0;
      set_v[FLG_RUN]   = hit_mode;
      set_v[FLG_RUN16] = hit_long;
      set_v[FLG_CW]    = hit_cw;
      clr_v[FLG_RUN]   = rd_run;
      clr_v[FLG_RUN16] = rd_run16;
      clr_v[FLG_CW]    = rd_cw;
   end

   for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
      lczd_sticky_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[g]),
         .clr_i  (clr_v[g]),
         .flag_o (flag_v[g])
      );
   end

   assign run_flag   = flag_v[FLG_RUN];
   assign run16_flag = flag_v[FLG_RUN16];
   assign cw_flag    = flag_v[FLG_CW];

   AST_PULSE_NO_RUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit && rd_run && rd_run16) |=> (!run_flag && !run16_flag)); // R5
   AST_READ_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cw && !rd_run && run_flag) |=> run_flag); // R12
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!run_flag && !run16_flag && !cw_flag)); // R1

endmodule

// File: tb/test_lczd_top.sv
`timescale 1ns/1ps
module test_lczd_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0, rx_bpv = 1'b0, t1_mode = 1'b0;
   logic rd_run = 1'b0, rd_run16 = 1'b0, rd_cw = 1'b0;
   logic run_flag, run16_flag, cw_flag;

   always #2.5 clk = ~clk;

   lczd_top i_lczd_top (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bpv(rx_bpv), .t1_mode(t1_mode),
      .rd_run(rd_run), .rd_run16(rd_run16), .rd_cw(rd_cw),
      .run_flag(run_flag), .run16_flag(run16_flag), .cw_flag(cw_flag)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // Bench model state: symbol codes 0 zero, 1 pulse, 2 violation, 3 empty.
   int  run;
   int  h [8];
   bit  e_run, e_run16, e_cw;

   task automatic check(input logic act, input bit exp, input string tag, input string name);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      check(run_flag,   e_run,   tag, "run_flag");
      check(run16_flag, e_run16, tag, "run16_flag");
      check(cw_flag,    e_cw,    tag, "cw_flag");
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input int sym, input bit bpv_on_zero, input bit rz, input bit r16,
                       input bit rc, input string tag);
      int  thr;
      bit  s_run, s_run16, s_cw;
      rx_bit   = (sym != 0);
      rx_bpv   = (sym == 2) || (sym == 0 && bpv_on_zero);
      rd_run   = rz;
      rd_run16 = r16;
      rd_cw    = rc;
      for (int k = 7; k > 0; k--) h[k] = h[k-1];
      h[0] = sym;
      run  = (sym == 0) ? ((run < 16) ? run + 1 : 16) : 0;
      thr  = t1_mode ? 8 : 4;
      s_run   = (sym == 0) && (run >= thr);
      s_run16 = (sym == 0) && (run >= 16);
      if (t1_mode)
         s_cw = h[0] == 1 && h[1] == 2 && h[2] == 0 && h[3] == 1 && h[4] == 2
             && h[5] == 0 && h[6] == 0 && h[7] == 0;
      else
         s_cw = h[0] == 2 && h[1] == 0 && h[2] == 0 && (h[3] == 0 || h[3] == 1);
      e_run   = s_run   | (e_run   & ~rz);
      e_run16 = s_run16 | (e_run16 & ~r16);
      e_cw    = s_cw    | (e_cw    & ~rc);
      @(posedge clk);
      #1;
      check_all(tag);
      @(negedge clk);
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0;
      t1_mode = mode;
      rx_bit = 1'b0; rx_bpv = 1'b0;
      rd_run = 1'b0; rd_run16 = 1'b0; rd_cw = 1'b0;
      run = 0; e_run = 0; e_run16 = 0; e_cw = 0;
      for (int k = 0; k < 8; k++) h[k] = 3;
      repeat (3) @(negedge clk);
      check_all("R1 reset state");
      rst_n = 1'b1;
   endtask

   initial begin
      int code, d;
      logic [15:0] lfsr;

      // R1: reset, then a partial HDB3 window right after reset must not match.
      do_reset(1'b0);
      step(0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, "R1");
      step(2, 0, 0, 0, 0, "R1 short window");

      // R2 R3 R4 R5 R6 R13: run sweep in both modes, reading every cycle.
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int len = 0; len <= 20; len++) begin
            for (int i = 0; i < len; i++) step(0, 0, 1, 1, 1, m ? "R3 R4 R6 run" : "R2 R4 R6 run");
            step(1, 0, 1, 1, 1, "R5 pulse ends run");
         end
         // R5: violation pulse also ends a run; bpv on a zero is ignored.
         for (int i = 0; i < 6; i++) step(0, (i % 2) == 1, 1, 1, 1, "R5 bpv on zero");
         step(2, 0, 1, 1, 1, "R5 violation ends run");
         for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, "R5 restart");
      end

      // R10 R11 R12: sticky behaviour, no reads until stated.
      do_reset(1'b0);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R2 R13");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R10 hold");
      step(1, 0, 0, 1, 1, "R12 other reads");
      step(1, 0, 1, 0, 0, "R10 read clears");
      step(1, 0, 0, 0, 0, "R10 stays clear");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R11 build");
      step(0, 0, 1, 0, 0, "R11 set with read");
      step(1, 0, 0, 0, 0, "R11 kept");

      // R7 R9: every 4-symbol window after a clearing pulse, both modes.
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int c = 0; c < 81; c++) begin
            step(1, 0, 1, 1, 1, "R7 R9 lead");
            code = c;
            for (int p = 0; p < 4; p++) begin
               d = code % 3; code = code / 3;
               step(d, 0, 1, 1, 1, m ? "R9 HDB3 in T1" : "R7 HDB3");
            end
         end
      end

      // R8 R9: every 8-symbol window, both modes.
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int c = 0; c < 6561; c++) begin
            step(1, 0, 1, 1, 1, "R8 R9 lead");
            code = c;
            for (int p = 0; p < 8; p++) begin
               d = code % 3; code = code / 3;
               step(d, 0, 1, 1, 1, m ? "R8 B8ZS" : "R9 B8ZS in E1");
            end
         end
      end

      // R6 R10 R11 R12: random symbols and sparse reads, with mode switches.
      do_reset(1'b1);
      lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         if (i == 3000) t1_mode = 1'b0;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         d = (lfsr[1:0] == 2'd2) ? 1 : (lfsr[1:0] == 2'd3) ? 2 : 0;
         step(d, lfsr[2], lfsr[4:3] == 2'd0, lfsr[6:5] == 2'd0, lfsr[8:7] == 2'd0,
              "R6 R10 R11 R12 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule